// File: doc/BRIEF.md
# Three-Wire Audio Control Word Receiver

This block takes 24-bit control words from a slow three-wire serial link made of a bit clock, a data line and a load strobe. It oversamples all three wires with the fast system clock and shifts in one bit on each rising edge of the bit clock. When the load strobe rises, the block copies the assembled word into one of five holding images. A format identifier carried in the top nibble of the word picks the image. One image holds the general routing and gain settings. The other four each hold the volume codes for a pair of channels.

The held codes drive a multichannel analog audio path. They cover two input selectors, an input attenuation step, input and output gain steps, two record enables, multi-input select and mute flags, a front-pair source flag, a global output mute, and eight volume step codes. Selector codes and volume codes that mean nothing are cleaned up on the way out. The two mute flags override the volume codes on the way out and leave the stored codes untouched. A frame is dropped whole when it is malformed, that is, when the wrong number of bits arrived or the identifier is unknown.

Top module: `audio_ctl_serial`

## Requirements
- R1: Frame bits are taken one per rising edge of the serial bit clock, first bit first. The first bit becomes word bit 0 and the 24th becomes word bit 23.
- R2: Settings change only on a rising edge of the load strobe. Shifting bits in, on their own, leaves every output as it was.
- R3: Word bits 23..20 form the identifier: 0 is the general image, 1 is channels FL/FR, 2 is C/SW, 3 is SL/SR and 4 is SBL/SBR. In a volume frame, bits 7..0 go to the first channel of the pair and bits 15..8 go to the second. The output `vol_o` packs channel k in bits 8k+7..8k, in the order FL, FR, C, SW, SL, SR, SBL, SBR.
- R4: A frame whose identifier is 5..15 changes nothing.
- R5: A load strobe that arrives after any count other than exactly 24 bit clock edges since the previous strobe (or since reset) changes nothing.
- R6: After reset, both selectors and all 2-bit fields read 0, all flags read 0, and every volume reads the mute code 199.
- R7: The general image layout is as follows. Selectors: main select in bits 3..0 and sub select in bits 7..4. Two-bit steps: input attenuation in 9..8, input gain in 16..15 and output gain in 18..17. Flags: bit 10 is record 1, bit 11 is record 2, bit 12 is multi select, bit 13 is multi mute, bit 14 is front-pair multi, and bit 19 is global mute.
- R8: A selector code of 10..15 is output as 0 (all inputs off). Codes 0..9 pass through unchanged.
- R9: A volume code of 200..255 is output as the mute code 199. Codes 0..199 pass through unchanged.
- R10: While global mute is set, all eight volume outputs read 199. Clearing it brings back the stored codes.
- R11: While multi mute is set, the six volumes other than FL and FR read 199, and FL and FR are unaffected.
- R12: A valid frame shows at the outputs within 4 system clocks of the strobe's rising edge, and not in the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_dat_i | input | 1 | Serial data |
| ser_lat_i | input | 1 | Load strobe |
| main_sel_o | output | 4 | Main input selector code |
| sub_sel_o | output | 4 | Sub input selector code |
| in_att_o | output | 2 | Input attenuation step (6 dB units) |
| in_gain_o | output | 2 | Input gain step (6 dB units) |
| out_gain_o | output | 2 | Output gain step (6 dB units) |
| rec1_o | output | 1 | Record output 1 enable |
| rec2_o | output | 1 | Record output 2 enable |
| multi_sel_o | output | 1 | Multi-input source select |
| multi_mute_o | output | 1 | Multi-input mute flag |
| front_multi_o | output | 1 | Front pair takes the multi input |
| all_mute_o | output | 1 | Global output mute flag |
| vol_o | output | 64 | Eight effective volume codes, 0.5 dB per step |

## Verification
A bit counter that drifts or a shift register that is out of phase would write a good frame into the wrong place. It would also either drop frames that should be accepted or accept frames that should be dropped. Either fault shows at the ports within four system clocks of the next strobe. An image written from the wrong identifier would change the volume pair of a different channel, and that difference is visible straight away. A fault in the override or cleanup logic shows with no strobe at all, because it is purely combinational. That is why each frame is followed by a compare of every output against a model that keeps its own copy of the stored codes.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ID_LSB     = 20;
  localparam int ID_W       = 4;
  localparam int NUM_PAIRS  = 4;
  localparam int NUM_CH     = 2 * NUM_PAIRS;
  localparam int VOL_W      = 8;
  localparam int VOL_MUTE   = 199;
  localparam int SEL_W      = 4;
  localparam int SEL_MAX    = 9;
  localparam int STEP_W     = 2;

  typedef struct packed {
    logic              all_mute;
    logic [STEP_W-1:0] out_gain;
    logic [STEP_W-1:0] in_gain;
    logic              front_multi;
    logic              multi_mute;
    logic              multi_sel;
    logic              rec2;
    logic              rec1;
    logic [STEP_W-1:0] in_att;
    logic [SEL_W-1:0]  sub_sel;
    logic [SEL_W-1:0]  main_sel;
  } gen_cfg_t;

  localparam int GEN_W = $bits(gen_cfg_t);
endpackage

// File: rtl/acs_sync.sv
module acs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] pipe_q;
    logic [STAGES:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-1:0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end

    assign level_o[g] = pipe_q[STAGES-1];
    assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/acs_frame.sv
module acs_frame
  import audio_ctl_pkg::*;
#(
  parameter int BITS      = FRAME_BITS,
  parameter int IDL       = ID_LSB,
  parameter int IDW       = ID_W,
  parameter int BANKS     = NUM_PAIRS + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_rise,
  input  logic            bit_val,
  input  logic            lat_rise,
  output logic            wr_en,
  output logic [IDW-1:0]  wr_id,
  output logic [BITS-1:0] wr_word
);
  localparam int CNT_MAX = BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [BITS-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (lat_rise) begin
      cnt_d = '0;
    end else if (bit_rise) begin
      sr_d = {bit_val, sr_q[BITS-1:1]};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_id   = sr_q[IDL +: IDW];
  assign wr_word = sr_q;
  assign wr_en   = lat_rise && (cnt_q == CNT_W'(BITS)) && (int'(wr_id) < BANKS);

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> cnt_q == '0) else $error("strobe did not clear bit count"); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rise && !lat_rise && cnt_q < CNT_W'(CNT_MAX)) |=> cnt_q == $past(cnt_q) + 1'b1)
    else $error("bit count missed an edge"); // R1
  AST_WR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> lat_rise) else $error("write without strobe"); // R2
endmodule

// File: rtl/acs_banks.sv
module acs_banks
  import audio_ctl_pkg::*;
#(
  parameter int BITS  = FRAME_BITS,
  parameter int IDW   = ID_W,
  parameter int PAIRS = NUM_PAIRS,
  parameter int VW    = VOL_W,
  parameter int MUTE  = VOL_MUTE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDW-1:0]     wr_id,
  input  logic [BITS-1:0]    wr_word,
  output gen_cfg_t           gen_q,
  output logic [2*PAIRS*VW-1:0] vol_q
);
  localparam int CH = 2 * PAIRS;

  gen_cfg_t gen_d;
  logic     gen_we;

  assign gen_we = wr_en && (wr_id == '0);

  always_comb begin
    gen_d = gen_q;
    if (gen_we) gen_d = gen_cfg_t'(wr_word[GEN_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_q <= '0;
    else        gen_q <= gen_d;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic          we;
    logic [VW-1:0] lo_q, hi_q, lo_d, hi_d;

    assign we = wr_en && (wr_id == IDW'(p + 1));

    always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (we) begin
        lo_d = wr_word[VW-1:0];
        hi_d = wr_word[2*VW-1:VW];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= VW'(MUTE);
        hi_q <= VW'(MUTE);
      end else begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign vol_q[(2*p)*VW   +: VW] = lo_q;
    assign vol_q[(2*p+1)*VW +: VW] = hi_q;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(gen_q) && $stable(vol_q))) else $error("image changed without write"); // R4
  AST_GEN_ONLY_ID0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_id != '0) |=> $stable(gen_q)) else $error("general image hit by volume frame"); // R3
endmodule

// File: rtl/acs_decode.sv
module acs_decode
  import audio_ctl_pkg::*;
#(
  parameter int CH   = NUM_CH,
  parameter int VW   = VOL_W,
  parameter int MUTE = VOL_MUTE,
  parameter int SW   = SEL_W,
  parameter int SMAX = SEL_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gen_cfg_t         gen_q,
  input  logic [CH*VW-1:0] vol_q,
  output logic [SW-1:0]    main_sel,
  output logic [SW-1:0]    sub_sel,
  output logic [CH*VW-1:0] vol_eff
);
  localparam int FRONT_CH = 2;

  always_comb begin
    main_sel = (int'(gen_q.main_sel) > SMAX) ? '0 : gen_q.main_sel;
    sub_sel  = (int'(gen_q.sub_sel)  > SMAX) ? '0 : gen_q.sub_sel;
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [VW-1:0] raw;
    logic          force_mute;
    assign raw = vol_q[c*VW +: VW];
    if (c < FRONT_CH) begin : g_front
      assign force_mute = gen_q.all_mute;
    end else begin : g_rest
      assign force_mute = gen_q.all_mute | gen_q.multi_mute;
    end
    always_comb begin
      if (force_mute || int'(raw) > MUTE) vol_eff[c*VW +: VW] = VW'(MUTE);
      else                                vol_eff[c*VW +: VW] = raw;
    end

    AST_VOL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(vol_eff[c*VW +: VW]) <= MUTE) else $error("volume above mute code"); // R9
  end

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(main_sel) <= SMAX) && (int'(sub_sel) <= SMAX)) else $error("selector out of range"); // R8
  AST_ALL_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q.all_mute |-> (vol_eff == {CH{VW'(MUTE)}})) else $error("global mute leaked"); // R10
  AST_FRONT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q.all_mute && int'(vol_q[VW-1:0]) <= MUTE) |-> vol_eff[VW-1:0] == vol_q[VW-1:0])
    else $error("front channel overridden"); // R11
endmodule

// File: rtl/audio_ctl_serial.sv
module audio_ctl_serial
  import audio_ctl_pkg::*;
#(
  parameter int N_PAIRS = NUM_PAIRS,
  parameter int VW      = VOL_W,
  parameter int SW      = SEL_W,
  parameter int STW     = STEP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_lat_i,
  output logic [SW-1:0]          main_sel_o,
  output logic [SW-1:0]          sub_sel_o,
  output logic [STW-1:0]         in_att_o,
  output logic [STW-1:0]         in_gain_o,
  output logic [STW-1:0]         out_gain_o,
  output logic                   rec1_o,
  output logic                   rec2_o,
  output logic                   multi_sel_o,
  output logic                   multi_mute_o,
  output logic                   front_multi_o,
  output logic                   all_mute_o,
  output logic [2*N_PAIRS*VW-1:0] vol_o
);
  localparam int CH = 2 * N_PAIRS;

  logic [2:0]            lvl, rise;
  logic                  wr_en;
  logic [ID_W-1:0]       wr_id;
  logic [FRAME_BITS-1:0] wr_word;
  gen_cfg_t              gen_q;
  logic [CH*VW-1:0]      vol_q;

  acs_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_lat_i, ser_dat_i, ser_clk_i}),
    .level_o(lvl), .rise_o(rise)
  );

  acs_frame #(.BANKS(N_PAIRS + 1)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(rise[0]), .bit_val(lvl[1]), .lat_rise(rise[2]),
    .wr_en(wr_en), .wr_id(wr_id), .wr_word(wr_word)
  );

  acs_banks #(.PAIRS(N_PAIRS), .VW(VW)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_id(wr_id), .wr_word(wr_word),
    .gen_q(gen_q), .vol_q(vol_q)
  );

  acs_decode #(.CH(CH), .VW(VW), .SW(SW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .gen_q(gen_q), .vol_q(vol_q),
    .main_sel(main_sel_o), .sub_sel(sub_sel_o), .vol_eff(vol_o)
  );

  assign in_att_o      = gen_q.in_att;
  assign in_gain_o     = gen_q.in_gain;
  assign out_gain_o    = gen_q.out_gain;
  assign rec1_o        = gen_q.rec1;
  assign rec2_o        = gen_q.rec2;
  assign multi_sel_o   = gen_q.multi_sel;
  assign multi_mute_o  = gen_q.multi_mute;
  assign front_multi_o = gen_q.front_multi;
  assign all_mute_o    = gen_q.all_mute;

  AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[2] |=> $stable(vol_o) && $stable(main_sel_o) && $stable(all_mute_o))
    else $error("outputs moved without strobe"); // R2
endmodule

// File: tb/tb_audio_ctl_serial.sv
module tb_audio_ctl_serial;
  localparam int HALF = 6;
  localparam int NV   = 12;
  localparam int MUTE = 199;

  logic clk = 1'b0;
  logic rst_n;
  logic sck, sdat, slat;
  logic [3:0] main_sel, sub_sel;
  logic [1:0] in_att, in_gain, out_gain;
  logic rec1, rec2, msel, mmute, fmulti, amute;
  logic [63:0] vol;

  int n_chk = 0, n_fail = 0;
  logic [19:0] m_gen;
  logic [7:0]  m_vol [8];

  // {bit count, frame word}
  localparam logic [28:0] VEC [NV] = '{
    {5'd24, 24'h03D693}, {5'd24, 24'h102805}, {5'd24, 24'h20C600},
    {5'd24, 24'h30FFC7}, {5'd24, 24'h40C864}, {5'd24, 24'h501111},
    {5'd24, 24'hF00000}, {5'd23, 24'h100101}, {5'd25, 24'h200101},
    {5'd24, 24'h0020FA}, {5'd24, 24'h080000}, {5'd24, 24'h000001}
  };

  always #2.5 clk = ~clk;

  audio_ctl_serial dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdat), .ser_lat_i(slat),
    .main_sel_o(main_sel), .sub_sel_o(sub_sel), .in_att_o(in_att),
    .in_gain_o(in_gain), .out_gain_o(out_gain), .rec1_o(rec1), .rec2_o(rec2),
    .multi_sel_o(msel), .multi_mute_o(mmute), .front_multi_o(fmulti),
    .all_mute_o(amute), .vol_o(vol)
  );

  function automatic string vec_tag(int i);
    case (i)
      0:       return "R1/R7";
      1, 2:    return "R3";
      3, 4:    return "R9";
      5, 6:    return "R4";
      7, 8:    return "R5";
      9:       return "R8/R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [23:0] w, int nb);
    for (int i = 0; i < nb; i++) begin
      sdat = (i < 24) ? w[i] : 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic strobe();
    slat = 1'b1;
    wait_clk(HALF);
    slat = 1'b0;
    wait_clk(HALF);
  endtask

  function automatic int exp_sel(logic [3:0] c);
    return (c > 9) ? 0 : int'(c);
  endfunction

  function automatic int exp_vol(int ch);
    if (m_gen[19]) return MUTE;
    if (m_gen[13] && ch >= 2) return MUTE;
    return (m_vol[ch] > MUTE) ? MUTE : int'(m_vol[ch]);
  endfunction

  task automatic model_apply(logic [23:0] w, int nb);
    int id = int'(w[23:20]);
    if (nb != 24 || id > 4) return;
    if (id == 0) m_gen = w[19:0];
    else begin
      m_vol[2*id-2] = w[7:0];
      m_vol[2*id-1] = w[15:8];
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, int'(main_sel), exp_sel(m_gen[3:0]));
    chk(tag, int'(sub_sel),  exp_sel(m_gen[7:4]));
    chk(tag, int'(in_att),   int'(m_gen[9:8]));
    chk(tag, int'(in_gain),  int'(m_gen[16:15]));
    chk(tag, int'(out_gain), int'(m_gen[18:17]));
    chk(tag, int'({amute, fmulti, mmute, msel, rec2, rec1}),
         int'({m_gen[19], m_gen[14:10]}));
    for (int c = 0; c < 8; c++) chk(tag, int'(vol[8*c +: 8]), exp_vol(c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; sdat = 1'b0; slat = 1'b0;
    m_gen = '0;
    for (int c = 0; c < 8; c++) m_vol[c] = 8'(MUTE);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    compare_all("R6");

    for (int i = 0; i < NV; i++) begin
      shift_bits(VEC[i][23:0], int'(VEC[i][28:24]));
      strobe();
      model_apply(VEC[i][23:0], int'(VEC[i][28:24]));
      compare_all(vec_tag(i));
    end

    // R2 and R12: bits alone change nothing; result lands within 4 clocks
    shift_bits(24'h107733, 24);
    wait_clk(4);
    chk("R2", int'(vol[7:0]), exp_vol(0));
    slat = 1'b1;
    wait_clk(1);
    chk("R12", int'(vol[7:0]), exp_vol(0));
    wait_clk(3);
    model_apply(24'h107733, 24);
    chk("R12", int'(vol[7:0]), 8'h33);
    chk("R12", int'(vol[15:8]), 8'h77);
    wait_clk(HALF);
    slat = 1'b0;
    wait_clk(HALF);

    // R5: strobe with no bits then a good frame still accepted
    strobe();
    compare_all("R5");
    shift_bits(24'h4A0102, 24);
    strobe();
    model_apply(24'h4A0102, 24);
    compare_all("R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule